// File: doc/BRIEF.md
# Playback DMA Byte Counter

This block runs the playback side of an audio codec's DMA engine. It decodes the playback format byte into a sample-rate index, a channel count and a sample-encoding code, and it rejects format codes that the playback path cannot handle. While playback is enabled and the format is valid, it holds a DMA request high. It counts each byte that the DMA controller acknowledges.

When the interrupt enable is set, the byte count is compared against a terminal count. The terminal count is the programmed 16-bit base count, shifted left by an amount that depends on sample width and channel count. When the last byte of a block is accepted, the block emits a one-cycle interrupt-set pulse, returns its counter to zero and keeps requesting. The surrounding register file turns that pulse into its sticky status and interrupt flags.

Top module: `pb_dma_counter`

## Requirements
- R1: `rateIdx` equals {fmtByte[0], fmtByte[3:1]}, combinationally. When fmtByte[0] is 0 and fmtByte[3:1] is 4 or 5, `fmtErr` is 1.
- R2: `chanCount` is 2 when fmtByte[4] is 1 and 1 when it is 0.
- R3: `fmtCode` equals fmtByte[7:5] when `extMode` is 1, and {0, fmtByte[6:5]} when `extMode` is 0.
- R4: Encoding codes 4, 5 and 7 set `fmtErr`. Codes 0, 1, 2, 3 and 6 do not, provided the rate is valid.
- R5: `dmaReq` rises one clock after `playEn` is 1 with `fmtErr` 0. It falls one clock after `playEn` goes to 0 or `fmtErr` goes to 1.
- R6: The terminal byte count is `baseCount` shifted left by a format-dependent amount. For codes 0, 1 and 3 the shift is 1 in stereo and 0 in mono. For codes 2 and 6 the shift is 2 in stereo and 1 in mono.
- R7: When an accepted acknowledge brings the count to the terminal count with `irqEn` 1, `irqPulse` is 1 for exactly the following cycle and the counter returns to zero. `dmaReq` stays 1.
- R8: With `irqEn` at 0, `irqPulse` never rises, however many bytes are accepted.
- R9: Each rise of `dmaReq` clears the byte counter.
- R10: A `baseCount` of zero makes every accepted byte raise `irqPulse` while `irqEn` is 1.
- R11: A `dmaAck` while `dmaReq` is 0 is not counted.
- R12: After reset, `dmaReq` and `irqPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtByte | input | 8 | Playback format byte |
| extMode | input | 1 | Extended mode: widens the encoding field to three bits |
| playEn | input | 1 | Playback enable |
| irqEn | input | 1 | Interrupt enable; arms the terminal-count limit |
| baseCount | input | 16 | Programmed block length in samples |
| dmaAck | input | 1 | One byte transferred in this cycle |
| dmaReq | output | 1 | DMA request |
| rateIdx | output | 4 | Table select in bit 3, rate code in bits 2:0 |
| chanCount | output | 2 | Number of channels (1 or 2) |
| fmtCode | output | 3 | Sample encoding code |
| fmtErr | output | 1 | Format rejected |
| irqPulse | output | 1 | One-cycle interrupt-set strobe |

## Verification
On every cycle, assertions check three things: the request falls after a disable or a format error, the counter holds still unless a count or clear strobe arrives, and every interrupt pulse follows an accepted byte with the interrupt armed and leaves the counter at zero. The exact terminal count for each encoding and channel mix is shown only by the bench's scenarios. The same holds for the restart after an error or re-enable and for the zero-length block.

// File: rtl/pb_dma_pkg.sv
package pb_dma_pkg;
  localparam int BASE_W    = 16;
  localparam int MAX_SHIFT = 2;
  localparam int CNT_W     = BASE_W + MAX_SHIFT;

  typedef enum logic [2:0] {
    ENC_U8     = 3'd0,
    ENC_MULAW  = 3'd1,
    ENC_S16LE  = 3'd2,
    ENC_ALAW   = 3'd3,
    ENC_RSVD4  = 3'd4,
    ENC_ADPCM  = 3'd5,
    ENC_S16BE  = 3'd6,
    ENC_RSVD7  = 3'd7
  } enc_e;

  typedef struct packed {
    logic clearCnt;
    logic countByte;
  } ctl_strobe_t;
endpackage

// File: rtl/pb_fmt_decode.sv
module pb_fmt_decode
  import pb_dma_pkg::*;
(
  input  logic [7:0] fmtByte,
  input  logic       extMode,
  output logic [3:0] rateIdx,
  output logic [1:0] chanCount,
  output logic [2:0] fmtCode,
  output logic [1:0] shiftAmt,
  output logic       fmtErr
);
  logic rateBad;
  logic encBad;
  logic stereo;
  enc_e enc;

  always_comb begin
    rateIdx   = {fmtByte[0], fmtByte[3:1]};
    rateBad   = !fmtByte[0] && (fmtByte[3:1] == 3'd4 || fmtByte[3:1] == 3'd5);
    stereo    = fmtByte[4];
    chanCount = stereo ? 2'd2 : 2'd1;
    enc       = extMode ? enc_e'(fmtByte[7:5]) : enc_e'({1'b0, fmtByte[6:5]});
    fmtCode   = enc;
    encBad    = 1'b0;
    shiftAmt  = 2'd0;
    unique case (enc)
      ENC_U8, ENC_MULAW, ENC_ALAW: shiftAmt = stereo ? 2'd1 : 2'd0;
      ENC_S16LE, ENC_S16BE:        shiftAmt = stereo ? 2'd2 : 2'd1;
      default:                     encBad   = 1'b1;
    endcase
    fmtErr = rateBad || encBad;
  end
endmodule

// File: rtl/pb_dma_control.sv
module pb_dma_control
  import pb_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        playEn,
  input  logic        fmtErr,
  input  logic        dmaAck,
  output logic        dmaReq,
  output ctl_strobe_t strobe
);
  logic running;
  logic runNext;

  assign runNext = playEn && !fmtErr;

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else       running <= runNext;
  end

  always_comb begin
    strobe.clearCnt  = runNext && !running;
    strobe.countByte = running && dmaAck;
  end

  assign dmaReq = running;

  // R5
  req_drop_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !playEn |=> !dmaReq);
  // R5
  req_drop_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |=> !dmaReq);
  // R9
  clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(strobe.clearCnt));
endmodule

// File: rtl/pb_count_datapath.sv
module pb_count_datapath
  import pb_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic              irqEn,
  input  logic [BASE_W-1:0] baseCount,
  input  logic [1:0]        shiftAmt,
  output logic              irqPulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] terminal;
  logic [CNT_W:0]   cntPlusOne;
  logic             hit;

  always_comb begin
    terminal   = CNT_W'(baseCount) << shiftAmt;
    cntPlusOne = {1'b0, cnt} + 1'b1;
    hit        = strobe.countByte && irqEn && (cntPlusOne >= {1'b0, terminal});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= hit && !strobe.clearCnt;
      if (strobe.clearCnt || hit) cnt <= '0;
      else if (strobe.countByte)  cnt <= cntPlusOne[CNT_W-1:0];
    end
  end

  // R7
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> cnt == '0);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(strobe.countByte));
  // R8
  irq_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(irqEn));
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countByte && !strobe.clearCnt) |=> $stable(cnt));
endmodule

// File: rtl/pb_dma_counter.sv
module pb_dma_counter
  import pb_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  fmtByte,
  input  logic        extMode,
  input  logic        playEn,
  input  logic        irqEn,
  input  logic [15:0] baseCount,
  input  logic        dmaAck,
  output logic        dmaReq,
  output logic [3:0]  rateIdx,
  output logic [1:0]  chanCount,
  output logic [2:0]  fmtCode,
  output logic        fmtErr,
  output logic        irqPulse
);
  logic [1:0]  shiftAmt;
  ctl_strobe_t strobe;

  pb_fmt_decode uDec (
    .fmtByte(fmtByte), .extMode(extMode), .rateIdx(rateIdx),
    .chanCount(chanCount), .fmtCode(fmtCode), .shiftAmt(shiftAmt), .fmtErr(fmtErr)
  );

  pb_dma_control uCtl (
    .clk(clk), .rstN(rstN), .playEn(playEn), .fmtErr(fmtErr),
    .dmaAck(dmaAck), .dmaReq(dmaReq), .strobe(strobe)
  );

  pb_count_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqEn(irqEn),
    .baseCount(baseCount), .shiftAmt(shiftAmt), .irqPulse(irqPulse)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!dmaReq && !irqPulse));
endmodule

// File: tb/pb_dma_counter_test.sv
`timescale 1ns/1ps
module pb_dma_counter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  fmtByte = 8'h00;
  logic        extMode = 1'b0;
  logic        playEn = 1'b0;
  logic        irqEn = 1'b0;
  logic [15:0] baseCount = 16'd0;
  logic        dmaAck = 1'b0;
  logic        dmaReq, fmtErr, irqPulse;
  logic [3:0]  rateIdx;
  logic [1:0]  chanCount;
  logic [2:0]  fmtCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pb_dma_counter uut (
    .clk(clk), .rstN(rstN), .fmtByte(fmtByte), .extMode(extMode),
    .playEn(playEn), .irqEn(irqEn), .baseCount(baseCount), .dmaAck(dmaAck),
    .dmaReq(dmaReq), .rateIdx(rateIdx), .chanCount(chanCount),
    .fmtCode(fmtCode), .fmtErr(fmtErr), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendAck(output logic sawIrq);
    @(negedge clk); dmaAck = 1'b1;
    @(posedge clk); #1; sawIrq = irqPulse;
    dmaAck = 1'b0;
  endtask

  // sends n acks, returns the 1-based index of the first irq seen (0 if none) and the irq total
  task automatic ackRun(input int n, output int firstIrq, output int irqTotal);
    logic s;
    firstIrq = 0; irqTotal = 0;
    for (int i = 1; i <= n; i++) begin
      sendAck(s);
      if (s) begin irqTotal++; if (firstIrq == 0) firstIrq = i; end
    end
  endtask

  task automatic setRun(input logic [7:0] f, input logic en);
    @(negedge clk); fmtByte = f; playEn = en;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 dmaReq", dmaReq, 0);
    check("R12 irqPulse", irqPulse, 0);
    rstN = 1'b1;
  endtask

  task automatic testDecode();
    extMode = 1'b0; fmtByte = 8'h0B; #1;       // table1, code5
    check("R1 rateIdx", rateIdx, 4'hD);
    check("R1 rate ok", fmtErr, 0);
    fmtByte = 8'h08; #1;                         // table0, code4
    check("R1 rate code4 err", fmtErr, 1);
    fmtByte = 8'h0A; #1;                         // table0, code5
    check("R1 rate code5 err", fmtErr, 1);
    fmtByte = 8'h10; #1;
    check("R2 stereo", chanCount, 2);
    fmtByte = 8'h00; #1;
    check("R2 mono", chanCount, 1);
    fmtByte = 8'hC0; #1;
    check("R3 masked code", fmtCode, 2);
    check("R4 masked valid", fmtErr, 0);
    extMode = 1'b1; #1;
    check("R3 wide code", fmtCode, 6);
    check("R4 code6 ok", fmtErr, 0);
    fmtByte = 8'h80; #1;
    check("R4 code4 err", fmtErr, 1);
    fmtByte = 8'hA0; #1;
    check("R4 code5 err", fmtErr, 1);
    fmtByte = 8'hE0; #1;
    check("R4 code7 err", fmtErr, 1);
    fmtByte = 8'h60; #1;
    check("R4 code3 ok", fmtErr, 0);
    extMode = 1'b0; fmtByte = 8'h00;
  endtask

  task automatic testBasicCount();
    int f, t;
    irqEn = 1'b1; baseCount = 16'd3;
    setRun(8'h00, 1'b1);
    check("R5 req rises", dmaReq, 1);
    ackRun(3, f, t);
    check("R6 R7 mono u8 terminal at 3", f, 3);
    check("R7 single pulse", t, 1);
    @(posedge clk); #1;
    check("R7 pulse one cycle", irqPulse, 0);
    check("R7 req stays", dmaReq, 1);
    ackRun(3, f, t);
    check("R7 counter restarted", f, 3);
  endtask

  task automatic testShifts();
    int f, t;
    baseCount = 16'd2;
    setRun(8'h00, 1'b0);
    setRun(8'h10, 1'b1);                         // u8 stereo: shift 1
    ackRun(4, f, t);
    check("R6 u8 stereo terminal 4", f, 4);
    setRun(8'h10, 1'b0);
    setRun(8'h50, 1'b1);                         // s16 stereo: shift 2
    ackRun(8, f, t);
    check("R6 s16 stereo terminal 8", f, 8);
    setRun(8'h50, 1'b0);
    setRun(8'h40, 1'b1);                         // s16 mono: shift 1
    ackRun(4, f, t);
    check("R6 s16 mono terminal 4", f, 4);
    setRun(8'h40, 1'b0);
    setRun(8'h20, 1'b1);                         // mu-law mono: shift 0
    ackRun(2, f, t);
    check("R6 mulaw mono terminal 2", f, 2);
  endtask

  task automatic testNoIrq();
    int f, t;
    irqEn = 1'b0;
    ackRun(10, f, t);
    check("R8 no irq when disarmed", t, 0);
    irqEn = 1'b1;
    setRun(8'h00, 1'b0);
  endtask

  task automatic testZeroBase();
    int f, t;
    baseCount = 16'd0;
    setRun(8'h00, 1'b1);
    ackRun(3, f, t);
    check("R10 zero base every byte", t, 3);
    setRun(8'h00, 1'b0);
  endtask

  task automatic testReEnable();
    int f, t;
    baseCount = 16'd3;
    setRun(8'h00, 1'b1);
    ackRun(2, f, t);
    setRun(8'h00, 1'b0);
    check("R5 req falls on disable", dmaReq, 0);
    ackRun(2, f, t);
    check("R11 ack ignored while idle", t, 0);
    setRun(8'h00, 1'b1);
    ackRun(3, f, t);
    check("R9 count cleared on re-enable", f, 3);
  endtask

  task automatic testFmtError();
    int f, t;
    ackRun(2, f, t);
    setRun(8'h08, 1'b1);                         // rate error
    check("R5 req falls on fmt error", dmaReq, 0);
    ackRun(1, f, t);
    check("R11 ack ignored after error", t, 0);
    setRun(8'h00, 1'b1);
    check("R5 req back after fix", dmaReq, 1);
    ackRun(3, f, t);
    check("R9 count cleared after error", f, 3);
    setRun(8'h00, 1'b0);
  endtask

  initial begin
    testReset();
    testDecode();
    testBasicCount();
    testShifts();
    testNoIrq();
    testZeroBase();
    testReEnable();
    testFmtError();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule